// File: doc/BRIEF.md
# Keyboard Scan-Code Port with Acknowledge

This block sits between a keyboard and a host I/O bus. When the keyboard strobes a byte onto its code lines, the block latches the byte and raises a keyboard interrupt request. Bits 6..0 of the byte are the key scan code, and bit 7 tells press (0) from release (1). The keyboard then waits, and the block takes no further codes until software acknowledges the current one.

Software reads the latched byte from the input port at offset 0 of a four-byte I/O window (default base 60H). To acknowledge, it writes bit 7 of the output port at offset 1 high and then low. The high-to-low transition of that bit, while a code is held, sends a one-cycle acknowledge pulse to the keyboard and drops the interrupt request. The input port at offset 2 reflects general input pins. The command register at offset 3 is a plain storage byte and does not change the fixed port directions.

Top module: `kbd_scan_port`

## Requirements
- R1: After reset the output port reads and drives 00H, the command register reads 00H, port A reads 00H, and both `key_irq` and `kb_ack` are 0.
- R2: A `kb_strobe` while no code is held latches `kb_code` and sets `key_irq` on the next clock. A read at offset 0 returns the byte unchanged, with the scan code in bits 6..0 and press (0) or release (1) in bit 7.
- R3: While a code is held, further strobes are ignored, and port A keeps returning the first byte.
- R4: A write at offset 1 drives `pb_out` from the next clock, and a read at offset 1 returns the last value written.
- R5: A write at offset 1 that takes bit 7 from 1 to 0 while a code is held makes `kb_ack` high for exactly the following cycle. In that same cycle `key_irq` falls, and a new strobe is accepted after it.
- R6: No acknowledge is given when bit 7 was already 0, when bit 7 is written to 1, or when no code is held. In these cases `key_irq` is unaffected.
- R7: A read at offset 2 returns `pc_in`. Writes at offsets 0 and 2 change nothing that can be read back.
- R8: A write at offset 3 is stored and read back at offset 3. It does not alter `pb_out`, port A contents or `key_irq`.
- R9: `io_rdata` is 00H when `io_rd` is low or the address is outside the four-byte window. Writes outside the window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kb_code | input | 8 | Byte presented by the keyboard |
| kb_strobe | input | 1 | Keyboard says a byte is valid |
| kb_ack | output | 1 | One-cycle acknowledge back to the keyboard |
| key_irq | output | 1 | Keyboard interrupt request |
| pc_in | input | 8 | Pins read through port C |
| pb_out | output | 8 | Output port B pins |
| io_addr | input | ADDR_W | I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |

## Verification
The bench targets a strobe arriving in the same cycle as the acknowledging write. A design that re-armed too early would latch that byte, and a design that blocked too long would refuse the next strobe. It writes bit 7 low while it already rests at 0, and also strobes the falling edge with no code held. An edge detector that ignored history, or ignored the held state, would then pulse `kb_ack` spuriously. It also checks that a second strobe during a held code leaves port A untouched, and that the command register and out-of-window writes leave `pb_out` and the latched code alone.

// File: rtl/kbd_scan_port.sv
module kbd_scan_port #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 'h60,
  parameter int ACK_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        kb_code,
  input  logic              kb_strobe,
  output logic              kb_ack,
  output logic              key_irq,
  input  logic [7:0]        pc_in,
  output logic [7:0]        pb_out,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata
);
  localparam logic [1:0] OFF_A = 2'd0;
  localparam logic [1:0] OFF_B = 2'd1;
  localparam logic [1:0] OFF_C = 2'd2;
  localparam logic [1:0] OFF_CMD = 2'd3;

  logic [7:0] code_q, pb_q, cmd_q;
  logic       pend_q, ack_q;

  wire       hit      = io_addr[ADDR_W-1:2] == BASE[ADDR_W-1:2];
  wire [1:0] sel      = io_addr[1:0];
  wire       wr_b     = io_wr && hit && sel == OFF_B;
  wire       wr_cmd   = io_wr && hit && sel == OFF_CMD;
  wire       ack_fire = wr_b && pb_q[ACK_BIT] && !io_wdata[ACK_BIT] && pend_q;

  assign kb_ack  = ack_q;
  assign key_irq = pend_q;
  assign pb_out  = pb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      pb_q   <= '0;
      cmd_q  <= '0;
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= ack_fire;
      if (wr_b)   pb_q  <= io_wdata;
      if (wr_cmd) cmd_q <= io_wdata;
      if (ack_fire) pend_q <= 1'b0;
      else if (kb_strobe && !pend_q) begin
        pend_q <= 1'b1;
        code_q <= kb_code;
      end
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd && hit)
      case (sel)
        OFF_A:   io_rdata = code_q;
        OFF_B:   io_rdata = pb_q;
        OFF_C:   io_rdata = pc_in;
        default: io_rdata = cmd_q;
      endcase
  end

  AST_IRQ_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(key_irq) |-> $past(kb_strobe)); // R2
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (key_irq && $past(key_irq)) |-> $stable(code_q)); // R3
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) kb_ack |=> !kb_ack); // R5
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n) kb_ack |-> (!key_irq && $past(key_irq))); // R5
  AST_ACK_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n) kb_ack |-> ($past(pb_out[ACK_BIT]) && !pb_out[ACK_BIT])); // R6
endmodule

// File: tb/sim_kbd_scan_port.sv
`timescale 1ns/1ps
module sim_kbd_scan_port;
  logic clk = 0, rst_n = 0;
  logic [7:0] kb_code = 0, pc_in = 0, io_wdata = 0;
  logic kb_strobe = 0, io_rd = 0, io_wr = 0;
  logic [15:0] io_addr = 0;
  logic kb_ack, key_irq;
  logic [7:0] pb_out, io_rdata;
  int checks = 0, errors = 0;

  logic [7:0] m_code = 0, m_pb = 0, m_cmd = 0;
  logic m_pend = 0, m_ack = 0;

  always #10 clk = ~clk;

  kbd_scan_port u0 (.clk(clk), .rst_n(rst_n), .kb_code(kb_code), .kb_strobe(kb_strobe),
    .kb_ack(kb_ack), .key_irq(key_irq), .pc_in(pc_in), .pb_out(pb_out), .io_addr(io_addr),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic rd, logic [15:0] a);
    if (!rd || a[15:2] != 14'h18) return 8'h00;
    case (a[1:0])
      2'd0: return m_code;
      2'd1: return m_pb;
      2'd2: return pc_in;
      default: return m_cmd;
    endcase
  endfunction

  task automatic cyc(string tag, logic stb, logic [7:0] code, logic wr, logic rd,
                     logic [15:0] a, logic [7:0] wd);
    kb_strobe = stb; kb_code = code; io_wr = wr; io_rd = rd; io_addr = a; io_wdata = wd;
    #2;
    if (rd) chk({tag, " rdata"}, io_rdata, exp_rd(rd, a));
    m_ack = wr && a == 16'h61 && m_pb[7] && !wd[7] && m_pend;
    if (wr && a == 16'h61) m_pb = wd;
    if (wr && a == 16'h63) m_cmd = wd;
    if (m_ack) m_pend = 0;
    else if (stb && !m_pend) begin m_pend = 1; m_code = code; end
    @(posedge clk); #1;
    chk({tag, " irq"}, {7'd0, key_irq}, {7'd0, m_pend});
    chk({tag, " ack"}, {7'd0, kb_ack}, {7'd0, m_ack});
    chk({tag, " pb"}, pb_out, m_pb);
    kb_strobe = 0; io_wr = 0; io_rd = 0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    pc_in = 8'h3C;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc("R1", 0, 0, 0, 1, 16'h60, 0);
    cyc("R1", 0, 0, 0, 1, 16'h61, 0);
    cyc("R1", 0, 0, 0, 1, 16'h63, 0);
    cyc("R2", 1, 8'h1E, 0, 0, 16'h00, 0);
    cyc("R2", 0, 0, 0, 1, 16'h60, 0);
    cyc("R3", 1, 8'h30, 0, 1, 16'h60, 0);
    cyc("R3", 0, 0, 0, 1, 16'h60, 0);
    cyc("R7", 0, 0, 1, 1, 16'h62, 8'hFF);
    cyc("R7", 0, 0, 1, 0, 16'h60, 8'h55);
    cyc("R7", 0, 0, 0, 1, 16'h60, 0);
    cyc("R8", 0, 0, 1, 0, 16'h63, 8'hA5);
    cyc("R8", 0, 0, 0, 1, 16'h63, 0);
    cyc("R8", 0, 0, 0, 1, 16'h60, 0);
    cyc("R9", 0, 0, 1, 1, 16'h0061, 8'h77);
    cyc("R9", 0, 0, 0, 1, 16'h0161, 0);
    cyc("R9", 0, 0, 0, 0, 16'h60, 0);
    cyc("R6", 0, 0, 1, 0, 16'h61, 8'h00);
    cyc("R4", 0, 0, 1, 0, 16'h61, 8'h81);
    cyc("R4", 0, 0, 0, 1, 16'h61, 0);
    cyc("R6", 0, 0, 1, 0, 16'h61, 8'h80);
    cyc("R5", 1, 8'h9E, 1, 0, 16'h61, 8'h00);
    cyc("R5", 0, 0, 0, 0, 16'h00, 0);
    cyc("R5", 1, 8'h9E, 0, 0, 16'h00, 0);
    cyc("R2", 0, 0, 0, 1, 16'h60, 0);
    cyc("R5", 0, 0, 1, 0, 16'h61, 8'h80);
    cyc("R5", 0, 0, 1, 0, 16'h61, 8'h00);
    cyc("R6", 0, 0, 1, 0, 16'h61, 8'h80);
    cyc("R6", 0, 0, 1, 0, 16'h61, 8'h00);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      a = 16'h60 + 16'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) a = 16'h64 + 16'($urandom_range(0, 60));
      cyc("R2-rand", $urandom_range(0, 3) == 0, 8'($urandom), $urandom_range(0, 2) == 0,
          $urandom_range(0, 1) == 1, a, 8'($urandom) & ($urandom_range(0, 1) ? 8'hFF : 8'h7F));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule